// File: doc/BRIEF.md
# Integer Execute Stage with Double-Width Multiply

This block is the purely combinational execute stage of a small five-stage 32-bit integer pipeline. Each cycle the decode latch hands it the instruction word, the next-instruction address, the two register operands and an immediate already sign-extended from sixteen bits. From these it forms the single result word that the memory latch stores, a flag saying whether a conditional branch is taken, and a second result word used only by the multiply.

The multiply returns the whole 64-bit signed product. The low word goes out on the ordinary result and the high word on its own port, so that writeback can fill two consecutive destination registers in one go. There are no hi/lo special registers. The stage also computes load and store addresses, resolves the equality branch, and produces the branch target on the ordinary result. Arithmetic wraps and never traps.

Top module: `exec_unit`

## Requirements
- R1: With major opcode 0, function 6'h20 gives `opa + opb` and function 6'h22 gives `opa - opb`, both modulo 2^32 with no overflow indication.
- R2: Opcodes 6'h08 (add immediate), 6'h23 (load word) and 6'h2B (store word) all give `opa + imm` modulo 2^32.
- R3: With major opcode 0, function 6'h24 gives `opa & opb` and 6'h25 gives `opa | opb`. Opcodes 6'h0C and 6'h0D AND or OR `opa` with `ir[15:0]` zero-extended, ignoring `imm`.
- R4: With major opcode 0, function 6'h00 shifts `opb` left and function 6'h02 shifts `opb` right, both logically by `ir[10:6]`.
- R5: Opcode 6'h0A gives 1 when `opa < imm` as signed values, else 0. Opcode 6'h0B gives the same with an unsigned compare.
- R6: Opcode 6'h0F gives `{ir[15:0], 16'h0000}`.
- R7: With major opcode 0 and function 6'h18, the operands are multiplied as signed values. Bits 31:0 of the 64-bit product go on `alu_out` and bits 63:32 on `mul_hi`.
- R8: `mul_hi` is zero for every instruction except the multiply.
- R9: Opcode 6'h04 sets `cond` to `opa == opb` and drives `alu_out` with `npc + (imm << 2)`.
- R10: `cond` is zero for every instruction other than opcode 6'h04.
- R11: Any opcode or opcode-0 function not listed above drives `alu_out`, `mul_hi` and `cond` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ir | input | 32 | Instruction word from the decode latch |
| npc | input | W | Address of the next sequential instruction |
| opa | input | W | First register operand (rs) |
| opb | input | W | Second register operand (rt) |
| imm | input | W | Immediate, sign-extended from `ir[15:0]` |
| alu_out | output | W | Result, low product word, memory address or branch target |
| mul_hi | output | W | High product word for the multiply, else zero |
| cond | output | 1 | Branch taken flag |

## Verification
The checks assume that `imm` always equals the sign extension of `ir[15:0]`, since decode produces it that way. They also assume that inputs hold steady long enough to be sampled, because the block has no clock. The stimulus builds every instruction word from its fields, drives `imm` from the same sixteen bits, and sets all inputs together half a cycle before sampling. Random operands are mixed with directed edge values such as the most negative word, all ones and zero, so the signed and unsigned views of the same bits part ways.

// File: rtl/exec_unit.sv
`timescale 1ns/1ps
module exec_unit #(
  parameter int W = 32
) (
  input  logic [31:0]  ir,
  input  logic [W-1:0] npc,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [W-1:0] imm,
  output logic [W-1:0] alu_out,
  output logic [W-1:0] mul_hi,
  output logic         cond
);
  localparam logic [5:0] OP_REG = 6'h00, OP_BEQ = 6'h04, OP_ADDI = 6'h08,
                         OP_SLTI = 6'h0A, OP_SLTIU = 6'h0B, OP_ANDI = 6'h0C,
                         OP_ORI = 6'h0D, OP_LUI = 6'h0F, OP_LW = 6'h23, OP_SW = 6'h2B;
  localparam logic [5:0] FN_SLL = 6'h00, FN_SRL = 6'h02, FN_MUL = 6'h18,
                         FN_ADD = 6'h20, FN_SUB = 6'h22, FN_AND = 6'h24, FN_OR = 6'h25;

  logic [5:0]     opc, fn;
  logic [4:0]     sh;
  logic [W-1:0]   zimm;
  logic [2*W-1:0] prod;

  assign opc  = ir[31:26];
  assign fn   = ir[5:0];
  assign sh   = ir[10:6];
  assign zimm = {{(W-16){1'b0}}, ir[15:0]};
  assign prod = $signed({{W{opa[W-1]}}, opa}) * $signed({{W{opb[W-1]}}, opb});

  always_comb begin
    alu_out = '0;
    mul_hi  = '0;
    cond    = 1'b0;
    case (opc)
      OP_REG: begin
        case (fn)
          FN_ADD: alu_out = opa + opb;
          FN_SUB: alu_out = opa - opb;
          FN_AND: alu_out = opa & opb;
          FN_OR:  alu_out = opa | opb;
          FN_SLL: alu_out = opb << sh;
          FN_SRL: alu_out = opb >> sh;
          FN_MUL: begin
            alu_out = prod[W-1:0];
            mul_hi  = prod[2*W-1:W];
          end
          default: ;
        endcase
      end
      OP_ADDI, OP_LW, OP_SW: alu_out = opa + imm;
      OP_ANDI:  alu_out = opa & zimm;
      OP_ORI:   alu_out = opa | zimm;
      OP_SLTI:  alu_out = {{(W-1){1'b0}}, $signed(opa) < $signed(imm)};
      OP_SLTIU: alu_out = {{(W-1){1'b0}}, opa < imm};
      OP_LUI:   alu_out = {ir[15:0], {(W-16){1'b0}}};
      OP_BEQ: begin
        cond    = (opa == opb);
        alu_out = npc + (imm << 2);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exec_unit_chk.sv
`timescale 1ns/1ps
module exec_unit_chk #(
  parameter int W = 32
) (
  input logic [31:0]  ir,
  input logic [W-1:0] npc,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [W-1:0] imm,
  input logic [W-1:0] alu_out,
  input logic [W-1:0] mul_hi,
  input logic         cond
);
  logic is_beq, is_mul, is_lui, is_slt, known;
  always_comb begin
    is_beq = ir[31:26] == 6'h04;
    is_mul = ir[31:26] == 6'h00 && ir[5:0] == 6'h18;
    is_lui = ir[31:26] == 6'h0F;
    is_slt = ir[31:26] == 6'h0A || ir[31:26] == 6'h0B;
    case (ir[31:26])
      6'h00: known = ir[5:0] inside {6'h00, 6'h02, 6'h18, 6'h20, 6'h22, 6'h24, 6'h25};
      6'h04, 6'h08, 6'h0A, 6'h0B, 6'h0C, 6'h0D, 6'h0F, 6'h23, 6'h2B: known = 1'b1;
      default: known = 1'b0;
    endcase
  end

  always_comb begin
    assert_cond_only_branch_R10: assert (is_beq || !cond);
    assert_cond_equal_R9: assert (!is_beq || cond == (opa == opb));
    assert_hi_quiet_R8: assert (is_mul || mul_hi == '0);
    assert_lui_low_zero_R6: assert (!is_lui || (alu_out[15:0] == 16'h0 && alu_out[31:16] == ir[15:0]));
    assert_slt_bool_R5: assert (!is_slt || alu_out[W-1:1] == '0);
    assert_mul_unit_R7: assert (!(is_mul && opb == 1) || (alu_out == opa && mul_hi == {W{opa[W-1]}}));
    assert_unknown_zero_R11: assert (known || (alu_out == '0 && mul_hi == '0 && !cond));
  end
endmodule

bind exec_unit exec_unit_chk #(.W(W)) chk (.*);

// File: tb/exec_unit_test.sv
`timescale 1ns/1ps
module exec_unit_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] ir, npc, opa, opb, imm;
  logic [31:0] alu_out, mul_hi;
  logic        cond;
  int checks = 0, failures = 0;
  bit done = 0;

  exec_unit uut (.ir(ir), .npc(npc), .opa(opa), .opb(opb), .imm(imm),
                 .alu_out(alu_out), .mul_hi(mul_hi), .cond(cond));

  function automatic logic [31:0] rw(input logic [4:0] sh, input logic [5:0] fn);
    return {6'h00, 5'd1, 5'd2, 5'd3, sh, fn};
  endfunction
  function automatic logic [31:0] iw(input logic [5:0] op, input logic [15:0] k);
    return {op, 5'd4, 5'd5, k};
  endfunction

  function automatic string tag(input logic [31:0] w);
    logic [5:0] op = w[31:26];
    if (op == 6'h00) begin
      case (w[5:0])
        6'h20, 6'h22: return "R1";
        6'h24, 6'h25: return "R3";
        6'h00, 6'h02: return "R4";
        6'h18: return "R7";
        default: return "R11";
      endcase
    end
    case (op)
      6'h08, 6'h23, 6'h2B: return "R2";
      6'h0C, 6'h0D: return "R3";
      6'h0A, 6'h0B: return "R5";
      6'h0F: return "R6";
      6'h04: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic model(input logic [31:0] w, input logic [31:0] n, a, b, k,
                       output logic [31:0] ea, eh, output logic ec);
    longint p;
    logic [31:0] z = {16'h0, w[15:0]};
    ea = 0; eh = 0; ec = 0;
    if (w[31:26] == 6'h00) begin
      case (w[5:0])
        6'h20: ea = a + b;
        6'h22: ea = a - b;
        6'h24: ea = a & b;
        6'h25: ea = a | b;
        6'h00: ea = b << w[10:6];
        6'h02: ea = b >> w[10:6];
        6'h18: begin
          p = longint'(signed'(a)) * longint'(signed'(b));
          ea = p[31:0]; eh = p[63:32];
        end
        default: ;
      endcase
    end else begin
      case (w[31:26])
        6'h08, 6'h23, 6'h2B: ea = a + k;
        6'h0C: ea = a & z;
        6'h0D: ea = a | z;
        6'h0A: ea = (signed'(a) < signed'(k)) ? 32'd1 : 32'd0;
        6'h0B: ea = (a < k) ? 32'd1 : 32'd0;
        6'h0F: ea = {w[15:0], 16'h0};
        6'h04: begin ec = (a == b); ea = n + {k[29:0], 2'b00}; end
        default: ;
      endcase
    end
  endtask

  task automatic run(input logic [31:0] w, input logic [31:0] n, a, b);
    logic [31:0] ea, eh;
    logic ec;
    string t;
    @(posedge clk);
    ir = w; npc = n; opa = a; opb = b; imm = {{16{w[15]}}, w[15:0]};
    model(w, n, a, b, imm, ea, eh, ec);
    t = tag(w);
    @(negedge clk);
    checks++;
    if (alu_out !== ea) begin
      failures++;
      $display("FAIL %s alu_out ir=%h actual=%h expected=%h", t, w, alu_out, ea);
    end
    if (mul_hi !== eh) begin
      failures++;
      $display("FAIL %s mul_hi ir=%h actual=%h expected=%h", (t == "R7") ? "R7" : "R8", w, mul_hi, eh);
    end
    if (cond !== ec) begin
      failures++;
      $display("FAIL %s cond ir=%h actual=%b expected=%b", (t == "R9") ? "R9" : "R10", w, cond, ec);
    end
  endtask

  initial begin
    logic [5:0] ops [10] = '{6'h00, 6'h08, 6'h23, 6'h2B, 6'h0C, 6'h0D, 6'h0A, 6'h0B, 6'h0F, 6'h04};
    logic [5:0] fns [7] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h00, 6'h02, 6'h18};
    ir = 0; npc = 0; opa = 0; opb = 0; imm = 0;
    void'($urandom(32'd2024));
    run(32'h0, 0, 0, 0);                                   // idle word, all zero
    run(rw(0, 6'h20), 0, 32'h7FFF_FFFF, 1);                // R1 wrap
    run(rw(0, 6'h22), 0, 0, 1);                            // R1 borrow
    run(iw(6'h23, 16'hFFFC), 0, 32'h100, 0);               // R2 negative offset
    run(iw(6'h0C, 16'h8000), 0, 32'hFFFF_FFFF, 0);         // R3 zero-extend
    run(iw(6'h0D, 16'hF00F), 0, 32'h1234_0000, 0);         // R3
    run(rw(31, 6'h00), 0, 0, 32'h0000_0003);               // R4
    run(rw(31, 6'h02), 0, 0, 32'h8000_0000);               // R4 logical
    run(iw(6'h0A, 16'h0000), 0, 32'hFFFF_FFFF, 0);         // R5 signed
    run(iw(6'h0B, 16'hFFFF), 0, 0, 0);                     // R5 unsigned
    run(iw(6'h0F, 16'hBEEF), 0, 32'h5555_5555, 0);         // R6
    run(rw(0, 6'h18), 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);    // R7
    run(rw(0, 6'h18), 0, 32'h8000_0000, 32'h8000_0000);    // R7
    run(rw(0, 6'h18), 0, 32'hFFFF_FFFE, 32'd3);            // R7 negative result
    run(iw(6'h04, 16'hFFFE), 32'h40, 32'd9, 32'd9);        // R9 taken, backward
    run(iw(6'h04, 16'h0010), 32'h40, 32'd9, 32'd8);        // R9 not taken
    run(iw(6'h3F, 16'h1234), 0, 32'hAAAA, 32'h5555);       // R11 opcode
    run(rw(0, 6'h19), 0, 32'hFFFF_FFFF, 32'd7);            // R11 function
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] op = ops[$urandom_range(0, 9)];
      logic [31:0] w = (op == 6'h00) ? rw(5'($urandom), fns[$urandom_range(0, 6)])
                                     : iw(op, 16'($urandom));
      logic [31:0] a = $urandom, b = $urandom;
      if ($urandom_range(0, 7) == 0) b = a;
      run(w, $urandom, a, b);
    end
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule